// File: doc/BRIEF.md
# I2S Stereo Receiver with Switchable Slot Length

This block takes a stereo I2S stream and turns it into left/right sample pairs of up to 18 bits for a DAC path. All logic runs on one fast system clock. As bit-clock master it divides that clock down and drives the bit clock and word select itself. As slave it oversamples bit clock, word select and serial data through synchronizers and finds the bit-clock rising edges.

A configuration bit sets the channel slot length to 16 or 32 bits. In 16-bit slots the whole word reaches the output, placed in the upper bits. In 32-bit slots only the 18 most significant bits are kept. Completed frames leave through a valid/ready stream port. A frame stays on the port until it is accepted. Frames that finish while the port is stalled are discarded: back-pressure never stalls the serial side, because the serial side cannot be paused. Configuration inputs may change only while reset is asserted.

Top module: `i2s_rx_slotsel`

## Requirements
- R1: While and after reset, out_valid, sck_out and ws_out are 0 until the first frame or bit clock is produced.
- R2: With cfg_master=1, sck_out stays high for cfg_div+1 system clocks and then low for cfg_div+1 system clocks, so its period is 2*(cfg_div+1) clocks. cfg_div must be at least 2.
- R3: With cfg_master=1, ws_out changes only in the clock where sck_out falls. It changes once every 16 bit clocks when cfg_wide=0 and once every 32 when cfg_wide=1.
- R4: With cfg_master=0, sck_out and ws_out stay 0. Bit timing comes from sck_in and ws_in, and each level of sck_in must last at least 3 system clocks.
- R5: Serial data is sampled at bit-clock rising edges, MSB first. A word's MSB is the bit after the one at which word select changes value, and that change bit is the word's LSB. Word select 0 carries the left channel and 1 the right channel.
- R6: With cfg_wide=0, the first 16 bits of a word go to sample bits [17:2] and bits [1:0] are 0. Any further bits in the same slot are ignored.
- R7: With cfg_wide=1, the first 18 bits of a word go to sample bits [17:0], and the remaining bits of the slot are ignored.
- R8: One clock after the LSB of a right word is captured, out_valid rises with the pair (the preceding left word, that right word). The first word-select change after reset only sets alignment. A right word with no complete left word before it since the last pair produces no output.
- R9: While out_valid=1 and out_ready=0, out_valid stays 1 and out_left/out_right stay unchanged. Pairs completed during that time are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master-mode clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: follow external ones |
| cfg_wide | input | 1 | Slot length select: 0 = 16 bits, 1 = 32 bits |
| cfg_div | input | DIV_W | Half-period of the generated bit clock, minus one, in system clocks |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial audio data |
| sck_out | output | 1 | Generated bit clock (master mode, else 0) |
| ws_out | output | 1 | Generated word select (master mode, else 0) |
| out_valid | output | 1 | Stereo pair available |
| out_ready | input | 1 | Sink accepts the pair |
| out_left | output | OUT_W | Left sample, MSB-aligned |
| out_right | output | OUT_W | Right sample, MSB-aligned |

## Verification
The assertions check on every cycle that a stalled pair holds steady, that 16-bit slots leave the two lowest sample bits clear, that the clock pins stay quiet in slave mode, and that generated word select moves only on a bit-clock fall. The bench's scenarios are needed to show bit order, the channel mapping, truncation to 18 bits, discarding of excess slot bits, the alignment rule after reset, dropping under stall, and the measured bit-clock and word-select periods. These depend on whole serial sequences rather than single cycles.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int NARROW_BITS = 16;
  localparam int NARROW_SLOT = 16;
  localparam int WIDE_SLOT   = 32;
  localparam int SLOT_CNT_W  = 6;
endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen
  import i2s_rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wide,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             ws,
  output logic             rise_evt
);
  logic [DIV_W-1:0]      dcnt;
  logic [SLOT_CNT_W-1:0] fcnt;
  logic [SLOT_CNT_W-1:0] flast;
  logic                  tick;

  assign flast    = wide ? SLOT_CNT_W'(WIDE_SLOT - 1) : SLOT_CNT_W'(NARROW_SLOT - 1);
  assign tick     = en && (dcnt == div);
  assign rise_evt = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      fcnt <= '0;
      sck  <= 1'b0;
      ws   <= 1'b0;
    end else if (!en) begin
      dcnt <= '0;
      fcnt <= '0;
      sck  <= 1'b0;
      ws   <= 1'b0;
    end else if (tick) begin
      dcnt <= '0;
      sck  <= ~sck;
      if (sck) begin
        // falling edge of the generated bit clock
        if (fcnt == flast) begin
          fcnt <= '0;
          ws   <= ~ws;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_rx_insync.sv
module i2s_rx_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic rise_evt,
  output logic ws_s,
  output logic sd_s
);
  localparam int LINES = 3;
  localparam int DEPTH = STAGES + 1;

  logic [LINES-1:0][DEPTH-1:0] pipe;
  logic [LINES-1:0]            raw;

  assign raw = {sd_in, ws_in, sck_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      for (int g = 0; g < LINES; g++) begin
        pipe[g] <= {pipe[g][DEPTH-2:0], raw[g]};
      end
    end
  end

  assign rise_evt = pipe[0][STAGES-1] && !pipe[0][STAGES];
  assign ws_s     = pipe[1][STAGES-1];
  assign sd_s     = pipe[2][STAGES-1];
endmodule

// File: rtl/i2s_rx_deframer.sv
module i2s_rx_deframer
  import i2s_rx_pkg::*;
#(
  parameter int OUT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             ws_bit,
  input  logic             sd_bit,
  input  logic             wide,
  output logic             frame_done,
  output logic [OUT_W-1:0] left_w,
  output logic [OUT_W-1:0] right_w
);
  logic [SLOT_CNT_W-1:0] idx;
  logic [OUT_W-1:0]      acc;
  logic [OUT_W-1:0]      acc_nxt;
  logic                  ws_prev;
  logic                  ws_known;
  logic                  primed;
  logic                  left_ok;
  int                    keep_n;

  always_comb begin
    keep_n  = wide ? OUT_W : NARROW_BITS;
    acc_nxt = acc;
    for (int k = 0; k < OUT_W; k++) begin
      if ((int'(idx) == k) && (k < keep_n)) acc_nxt[OUT_W-1-k] = sd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      acc        <= '0;
      ws_prev    <= 1'b0;
      ws_known   <= 1'b0;
      primed     <= 1'b0;
      left_ok    <= 1'b0;
      frame_done <= 1'b0;
      left_w     <= '0;
      right_w    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (bit_evt) begin
        if (!ws_known) begin
          ws_known <= 1'b1;
          ws_prev  <= ws_bit;
          idx      <= '0;
          acc      <= '0;
        end else if (ws_bit != ws_prev) begin
          // this bit closes the word of channel ws_prev
          ws_prev <= ws_bit;
          idx     <= '0;
          acc     <= '0;
          primed  <= 1'b1;
          if (primed) begin
            if (!ws_prev) begin
              left_w  <= acc_nxt;
              left_ok <= 1'b1;
            end else begin
              if (left_ok) begin
                right_w    <= acc_nxt;
                frame_done <= 1'b1;
              end
              left_ok <= 1'b0;
            end
          end
        end else begin
          acc <= acc_nxt;
          if (idx != '1) idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_rx_slotsel.sv
module i2s_rx_slotsel
  import i2s_rx_pkg::*;
#(
  parameter int OUT_W       = 18,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_wide,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             sck_in,
  input  logic             ws_in,
  input  logic             sd_in,
  output logic             sck_out,
  output logic             ws_out,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  logic             gen_rise;
  logic             ext_rise;
  logic             ext_ws;
  logic             sd_s;
  logic             bit_evt;
  logic             ws_bit;
  logic             frame_done;
  logic [OUT_W-1:0] left_w;
  logic [OUT_W-1:0] right_w;

  i2s_rx_clkgen #(.DIV_W(DIV_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_master),
    .wide     (cfg_wide),
    .div      (cfg_div),
    .sck      (sck_out),
    .ws       (ws_out),
    .rise_evt (gen_rise)
  );

  i2s_rx_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck_in),
    .ws_in    (ws_in),
    .sd_in    (sd_in),
    .rise_evt (ext_rise),
    .ws_s     (ext_ws),
    .sd_s     (sd_s)
  );

  assign bit_evt = cfg_master ? gen_rise : ext_rise;
  assign ws_bit  = cfg_master ? ws_out   : ext_ws;

  i2s_rx_deframer #(.OUT_W(OUT_W)) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_evt    (bit_evt),
    .ws_bit     (ws_bit),
    .sd_bit     (sd_s),
    .wide       (cfg_wide),
    .frame_done (frame_done),
    .left_w     (left_w),
    .right_w    (right_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (out_valid && !out_ready) begin
      out_valid <= 1'b1;
    end else if (frame_done) begin
      out_valid <= 1'b1;
      out_left  <= left_w;
      out_right <= right_w;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_rx_slotsel_chk.sv
module i2s_rx_slotsel_chk
  import i2s_rx_pkg::*;
#(
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             cfg_wide,
  input logic             sck_out,
  input logic             ws_out,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right
);
  localparam int PAD_W = OUT_W - NARROW_BITS;

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_narrow_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_wide) |-> (out_left[PAD_W-1:0] == '0 && out_right[PAD_W-1:0] == '0));

  assert_slave_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!sck_out && !ws_out));

  assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(ws_out)) |-> $fell(sck_out));
endmodule

bind i2s_rx_slotsel i2s_rx_slotsel_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_master (cfg_master),
  .cfg_wide   (cfg_wide),
  .sck_out    (sck_out),
  .ws_out     (ws_out),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right)
);

// File: tb/test_i2s_rx_slotsel.sv
`timescale 1ns/1ps
module test_i2s_rx_slotsel;
  localparam int OUT_W = 18;
  localparam int DIV_W = 8;
  localparam int HALF  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_master = 1'b0;
  logic             cfg_wide = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic             sck_in = 1'b0;
  logic             ws_in = 1'b0;
  logic             sd_in = 1'b0;
  logic             sck_out;
  logic             ws_out;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [OUT_W-1:0] out_left;
  logic [OUT_W-1:0] out_right;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [2*OUT_W-1:0] exp_q[$];
  string              cur_req = "R5";
  bit                 mmode = 1'b0;
  logic [OUT_W-1:0]   m_l;
  logic [OUT_W-1:0]   m_r;
  int                 m_hs = 0;
  bit                 hold_prev = 1'b0;
  logic [OUT_W-1:0]   held_l;
  logic [OUT_W-1:0]   held_r;

  always #2.5 clk = ~clk;

  i2s_rx_slotsel #(.OUT_W(OUT_W), .DIV_W(DIV_W)) i_i2s_rx_slotsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_wide   (cfg_wide),
    .cfg_div    (cfg_div),
    .sck_in     (sck_in),
    .ws_in      (ws_in),
    .sd_in      (sd_in),
    .sck_out    (sck_out),
    .ws_out     (ws_out),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_left   (out_left),
    .out_right  (out_right)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [OUT_W-1:0] expect_word(input logic [31:0] w, input int slot, input bit wide);
    if (wide) return OUT_W'((w >> (slot - OUT_W)) & 32'h3FFFF);
    return {16'((w >> (slot - 16)) & 32'hFFFF), 2'b00};
  endfunction

  always @(posedge clk) cyc++;

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        check(out_valid && out_left == held_l && out_right == held_r, "R9", "stalled pair held",
              {out_valid, out_left, out_right}, {1'b1, held_l, held_r});
      if (out_valid && out_ready) begin
        if (mmode) begin
          m_hs++;
          check(out_left == m_l && out_right == m_r, cur_req, "master pair",
                {out_left, out_right}, {m_l, m_r});
        end else if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected pair", {out_left, out_right}, 0);
        end else begin
          logic [2*OUT_W-1:0] e;
          e = exp_q.pop_front();
          check({out_left, out_right} == e, cur_req, "pair", {out_left, out_right}, e);
        end
      end
      hold_prev = out_valid && !out_ready;
      held_l    = out_left;
      held_r    = out_right;
    end else begin
      hold_prev = 1'b0;
    end
  end

  task automatic do_reset(input bit master, input bit wide, input int div);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_master = master;
    cfg_wide = wide;
    cfg_div = DIV_W'(div);
    sck_in = 1'b0;
    ws_in = 1'b0;
    sd_in = 1'b0;
    exp_q.delete();
    mmode = 1'b0;
    m_hs = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // slave-mode transmitter: words right-aligned in 32 bits, slot bits per channel
  task automatic tx_frame(input int slot, input logic [31:0] lw, input logic [31:0] rw);
    for (int j = 0; j < 2 * slot; j++) begin
      @(negedge clk);
      sck_in = 1'b0;
      sd_in  = (j < slot) ? lw[slot-1-j] : rw[2*slot-1-j];
      ws_in  = (j >= slot - 1) && (j <= 2 * slot - 2);
      repeat (HALF - 1) @(negedge clk);
      sck_in = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic tx_checked(input int slot, input bit wide, input logic [31:0] lw, input logic [31:0] rw);
    exp_q.push_back({expect_word(lw, slot, wide), expect_word(rw, slot, wide)});
    tx_frame(slot, lw, rw);
  endtask

  task automatic settle_and_drain(input string req);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, req, "pending expected pairs", exp_q.size(), 0);
  endtask

  // master-mode run: follows sck_out/ws_out, sends constant words, measures timing
  task automatic run_master(input int ncyc, input int slot, input int div,
                            input logic [31:0] lw, input logic [31:0] rw);
    int last_rise = -1;
    int per = -1;
    int rises = 0;
    int phase_len = -1;
    int phases = 0;
    int idx = 0;
    logic psck = 1'b0;
    logic pws = 1'b0;
    logic [31:0] cur = '0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (sck_out && !psck) begin
        if (last_rise >= 0) per = c - last_rise;
        last_rise = c;
        rises++;
      end
      if (!sck_out && psck) begin
        sd_in = cur[idx];
        if (ws_out != pws) begin
          cur = ws_out ? rw : lw;
          idx = slot - 1;
        end else if (idx > 0) begin
          idx--;
        end
      end
      if (ws_out != pws) begin
        phases++;
        if (phases >= 2) phase_len = rises;
        rises = 0;
      end
      psck = sck_out;
      pws  = ws_out;
    end
    check(per == 2 * (div + 1), "R2", "bit clock period", per, 2 * (div + 1));
    check(phase_len == slot, "R3", "bit clocks per word select phase", phase_len, slot);
  endtask

  initial begin
    fork
      begin
        // R1: reset state
        @(negedge clk);
        check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
        check(!sck_out && !ws_out, "R1", "clock pins in reset", {sck_out, ws_out}, 0);
        do_reset(1'b0, 1'b0, 0);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);

        // R5/R6/R8: slave, 16-bit slots; the first frame only aligns
        cur_req = "R5";
        tx_frame(16, 32'h1234, 32'h5678);
        tx_checked(16, 1'b0, 32'h8001, 32'h7FFE);
        tx_checked(16, 1'b0, 32'hFFFF, 32'h0000);
        tx_checked(16, 1'b0, 32'hA55A, 32'h3C0F);
        settle_and_drain("R8");
        check(!sck_out && !ws_out, "R4", "clock pins in slave mode", {sck_out, ws_out}, 0);

        // R6: 16-bit mode with 20-bit slots, extra bits ignored
        do_reset(1'b0, 1'b0, 0);
        cur_req = "R6";
        tx_frame(20, 32'hFFFFF, 32'hFFFFF);
        tx_checked(20, 1'b0, 32'h9ABCF, 32'h1234F);
        tx_checked(20, 1'b0, 32'h0000F, 32'hFFFF0);
        settle_and_drain("R6");

        // R7: 32-bit slots keep the top 18 bits
        do_reset(1'b0, 1'b1, 0);
        cur_req = "R7";
        tx_frame(32, 32'hFFFFFFFF, 32'h0);
        tx_checked(32, 1'b1, 32'hDEADBEEF, 32'h01234567);
        tx_checked(32, 1'b1, 32'h0000C000, 32'hFFFF3FFF);
        settle_and_drain("R7");
        check(!sck_out && !ws_out, "R4", "clock pins in slave wide mode", {sck_out, ws_out}, 0);

        // R9: stall across several frames keeps only the first
        do_reset(1'b0, 1'b0, 0);
        cur_req = "R9";
        out_ready = 1'b0;
        tx_frame(16, 32'h0, 32'h0);
        tx_checked(16, 1'b0, 32'h1111, 32'h2222);
        tx_frame(16, 32'h3333, 32'h4444);
        tx_frame(16, 32'h5555, 32'h6666);
        repeat (10) @(negedge clk);
        check(out_valid, "R9", "valid held while stalled", out_valid, 1);
        out_ready = 1'b1;
        settle_and_drain("R9");
        check(!out_valid, "R9", "no dropped pair delivered later", out_valid, 0);

        // R2/R3: master, 16-bit slots
        do_reset(1'b1, 1'b0, 3);
        cur_req = "R5";
        mmode = 1'b1;
        m_l = expect_word(32'hA5C3, 16, 1'b0);
        m_r = expect_word(32'h1E69, 16, 1'b0);
        run_master(2000, 16, 3, 32'hA5C3, 32'h1E69);
        check(m_hs >= 3, "R8", "master pairs delivered", m_hs, 3);

        // R2/R3/R7: master, 32-bit slots
        do_reset(1'b1, 1'b1, 2);
        cur_req = "R7";
        mmode = 1'b1;
        m_l = expect_word(32'hC0FFEE11, 32, 1'b1);
        m_r = expect_word(32'h7BADF00D, 32, 1'b1);
        run_master(3000, 32, 2, 32'hC0FFEE11, 32'h7BADF00D);
        check(m_hs >= 2, "R8", "master wide pairs delivered", m_hs, 2);
      end
      begin
        wait (cyc >= 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule